// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter

This block decides which of four bus masters owns one slave port of a crossbar switch. Each master raises a request, holds a transaction-in-progress flag while it is using the port, and may raise an elevation input to be served ahead of the others for as long as that input stays high. The arbiter drives a registered one-hot grant and a stall for every master that is requesting but does not own the port. A crossbar with three slave ports uses three instances, one per port.

A small configuration register selects the arbitration rule and holds a 2-bit priority for each master. In fixed mode the highest programmed priority wins. In round-robin mode all masters are equal and the search starts just after the master granted last. Software may rewrite the register at any time. The new contents are used at the next arbitration point and never disturb a transaction that is in progress.

Top module: `xbar_port_arbiter`

## Requirements
- R1: During and right after a synchronous reset, grant is all zeros, the mode is fixed, every priority is 0 and the last-granted ID is 3, so the first round-robin grant goes to master 0.
- R2: grant is zero or one-hot. It changes only on the clock edge that ends an arbitration cycle: a cycle in which no granted master has busy high. The new grant is visible one cycle after that cycle.
- R3: While the granted master keeps busy high, grant stays unchanged whatever the other inputs do. No owner is preempted.
- R4: In fixed mode (cfg_mode = 0), the requester with the largest 2-bit priority is granted. Priority 3 is the most urgent. Equal priorities go to the lower master index.
- R5: In round-robin mode (cfg_mode = 1), the grant goes to the first requester found when searching upward from the last-granted ID plus one and wrapping from 3 to 0.
- R6: A requester with elev high beats every requester with elev low. Among elevated requesters, the rule of the current mode decides.
- R7: When cfg_we is high at a clock edge, cfg_mode and cfg_prio are loaded. Master i's priority is in cfg_prio[2i+1:2i]. The new values take effect at arbitration points from the next cycle on and leave a held grant unchanged.
- R8: At an arbitration point with no request, grant stays parked on the last owner, and the last-granted ID does not move.
- R9: stall[i] is high exactly when req[i] is high and grant[i] is low, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Request, one bit per master |
| busy | input | 4 | Transaction in progress, one bit per master |
| elev | input | 4 | Temporary priority elevation, one bit per master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 1 | 0 = fixed priority, 1 = round robin |
| cfg_prio | input | 8 | Per-master 2-bit priorities, master i at [2i+1:2i] |
| grant | output | 4 | Registered one-hot grant |
| stall | output | 4 | Requesting but not granted |

## Verification
A grant decision is made from the inputs of an arbitration cycle and is due at the outputs one clock edge later. A configuration write is applied at its edge and first affects the decision in the following cycle. Stall depends only on the current inputs and the current grant, so it is due in the same cycle. The bench drives inputs after the falling edge and advances a behavioural model at each rising edge with the same inputs. It then compares grant and stall against that model at the next falling edge, so every result is checked exactly in the cycle it is due.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/xarb_cfg_reg.sv
module xarb_cfg_reg
  import xbar_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          mode_in,
  input  logic [N*PW-1:0] prio_in,
  output arb_mode_e     mode,
  output logic [N*PW-1:0] prio
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= ARB_FIXED;
      prio <= '0;
    end else if (we) begin
      mode <= arb_mode_e'(mode_in);
      prio <= prio_in;
    end
  end
endmodule

// File: rtl/xarb_fixed_pick.sv
module xarb_fixed_pick #(
  parameter int N  = 4,
  parameter int PW = 2,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio,
  output logic            valid,
  output logic [IW-1:0]   idx
);
  logic [PW-1:0] best;
  // Scan downward; ">=" lets a lower index take over on a tie.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (!valid || prio[i*PW +: PW] >= best)) begin
        valid = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/xarb_rr_pick.sv
module xarb_rr_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] last,
  output logic          valid,
  output logic [IW-1:0] idx
);
  int j;
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    j     = 0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last) + k) % N;
      if (!valid && cand[j]) begin
        valid = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/xarb_grant_reg.sv
module xarb_grant_reg #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arb_en,
  input  logic          win_valid,
  input  logic [IW-1:0] win_idx,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] last_id
);
  logic [N-1:0] win_onehot;
  always_comb begin
    win_onehot = '0;
    win_onehot[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant   <= '0;
      last_id <= IW'(N - 1);
    end else if (arb_en && win_valid) begin
      grant   <= win_onehot;
      last_id <= win_idx;
    end
  end
endmodule

// File: rtl/xbar_port_arbiter.sv
module xbar_port_arbiter
  import xbar_arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int PRIO_W    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MASTERS-1:0]    req,
  input  logic [N_MASTERS-1:0]    busy,
  input  logic [N_MASTERS-1:0]    elev,
  input  logic                    cfg_we,
  input  logic                    cfg_mode,
  input  logic [N_MASTERS*PRIO_W-1:0] cfg_prio,
  output logic [N_MASTERS-1:0]    grant,
  output logic [N_MASTERS-1:0]    stall
);
  localparam int IW = $clog2(N_MASTERS);

  arb_mode_e                   mode_q;
  logic [N_MASTERS*PRIO_W-1:0] prio_q;
  logic [N_MASTERS-1:0]        elev_req;
  logic [N_MASTERS-1:0]        cand;
  logic                        arb_en;
  logic                        fx_valid, rr_valid, win_valid;
  logic [IW-1:0]               fx_idx, rr_idx, win_idx, last_id;

  xarb_cfg_reg #(.N(N_MASTERS), .PW(PRIO_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .mode_in(cfg_mode),
    .prio_in(cfg_prio), .mode(mode_q), .prio(prio_q)
  );

  // Elevated requesters form the candidate set when any exist.
  assign elev_req = req & elev;
  assign cand     = (|elev_req) ? elev_req : req;

  // Arbitration point: the current owner (if any) is not busy.
  assign arb_en = ~|(grant & busy);

  xarb_fixed_pick #(.N(N_MASTERS), .PW(PRIO_W)) u_fixed (
    .cand(cand), .prio(prio_q), .valid(fx_valid), .idx(fx_idx)
  );

  xarb_rr_pick #(.N(N_MASTERS)) u_rr (
    .cand(cand), .last(last_id), .valid(rr_valid), .idx(rr_idx)
  );

  always_comb begin
    if (mode_q == ARB_ROUND) begin
      win_valid = rr_valid;
      win_idx   = rr_idx;
    end else begin
      win_valid = fx_valid;
      win_idx   = fx_idx;
    end
  end

  xarb_grant_reg #(.N(N_MASTERS)) u_grant (
    .clk(clk), .rst(rst), .arb_en(arb_en), .win_valid(win_valid),
    .win_idx(win_idx), .grant(grant), .last_id(last_id)
  );

  assign stall = req & ~grant;
endmodule

// File: rtl/xarb_checker.sv
module xarb_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic [N-1:0] busy,
  input logic [N-1:0] elev,
  input logic [N-1:0] grant,
  input logic [N-1:0] stall
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> grant == '0);
  // R2
  a_r2_grant_onehot0: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  // R3
  a_r3_owner_held: assert property (@(posedge clk) disable iff (rst)
    (|(grant & busy)) |=> $stable(grant));
  // R2
  a_r2_grant_to_requester: assert property (@(posedge clk) disable iff (rst)
    (!(|(grant & busy)) && (|req)) |=> (|(grant & $past(req))));
  // R6
  a_r6_elevated_wins: assert property (@(posedge clk) disable iff (rst)
    (!(|(grant & busy)) && (|(req & elev))) |=> (|(grant & $past(req & elev))));
  // R8
  a_r8_parked: assert property (@(posedge clk) disable iff (rst)
    (!(|(grant & busy)) && req == '0) |=> $stable(grant));
  // R9
  a_r9_no_stall_owner: assert property (@(posedge clk) disable iff (rst)
    (stall & grant) == '0);
endmodule

bind xbar_port_arbiter xarb_checker #(.N(N_MASTERS)) u_chk (
  .clk(clk), .rst(rst), .req(req), .busy(busy), .elev(elev),
  .grant(grant), .stall(stall)
);

// File: tb/tb_xbar_port_arbiter.sv
module tb_xbar_port_arbiter;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] req, busy, elev;
  logic       cfg_we, cfg_mode;
  logic [7:0] cfg_prio;
  logic [3:0] grant, stall;

  always #2 clk = ~clk;  // 250 MHz

  xbar_port_arbiter dut (
    .clk(clk), .rst(rst), .req(req), .busy(busy), .elev(elev),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_prio(cfg_prio),
    .grant(grant), .stall(stall)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference model
  int m_grant = -1, m_last = 3, m_mode = 0;
  int m_prio[4] = '{0, 0, 0, 0};
  int pick, best, j;
  bit hold, anyel;
  bit cnd[4];

  always @(posedge clk) begin
    if (rst) begin
      m_grant <= -1; m_last <= 3; m_mode <= 0;
      for (int i = 0; i < 4; i++) m_prio[i] <= 0;
    end else begin
      hold = (m_grant >= 0) && busy[m_grant];
      if (!hold) begin
        anyel = |(req & elev);
        for (int i = 0; i < 4; i++) cnd[i] = req[i] && (!anyel || elev[i]);
        pick = -1;
        if (m_mode == 0) begin
          best = -1;
          for (int i = 0; i < 4; i++)
            if (cnd[i] && m_prio[i] > best) begin pick = i; best = m_prio[i]; end
        end else begin
          for (int k = 1; k <= 4; k++) begin
            j = (m_last + k) % 4;
            if (cnd[j] && pick < 0) pick = j;
          end
        end
        if (pick >= 0) begin m_grant <= pick; m_last <= pick; end
      end
      if (cfg_we) begin
        m_mode <= int'(cfg_mode);
        for (int i = 0; i < 4; i++) m_prio[i] <= int'(cfg_prio[2*i +: 2]);
      end
    end
  end

  function automatic logic [3:0] exp_grant();
    return (m_grant < 0) ? 4'b0000 : 4'(1 << m_grant);
  endfunction

  task automatic step();
    @(negedge clk);
    checks++;
    if (grant !== exp_grant()) begin
      fails++;
      $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp_grant());
    end
    checks++;
    if (stall !== (req & ~exp_grant())) begin
      fails++;
      $display("FAIL R9 (%s) stall actual=%b expected=%b", tag, stall, req & ~exp_grant());
    end
  endtask

  task automatic cfg(input bit md, input logic [7:0] p);
    cfg_we = 1; cfg_mode = md; cfg_prio = p;
    step();
    cfg_we = 0;
  endtask

  task automatic drive(input logic [3:0] r, input logic [3:0] b, input logic [3:0] e, input int n);
    req = r; busy = b; elev = e;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    rst = 1; req = 0; busy = 0; elev = 0; cfg_we = 0; cfg_mode = 0; cfg_prio = 0;
    tag = "R1"; step(); step();
    rst = 0;
    tag = "R1"; drive(4'b0000, 0, 0, 2);
    // R4 tie at reset priorities: lowest index
    tag = "R4"; drive(4'b1110, 0, 0, 2);
    // R4 programmed priorities m0=0 m1=1 m2=3 m3=2
    tag = "R7"; cfg(0, {2'd2, 2'd3, 2'd1, 2'd0});
    tag = "R4"; drive(4'b1111, 0, 0, 2);
    tag = "R3"; drive(4'b1111, 4'b0100, 4'b0001, 4);
    tag = "R4"; drive(4'b1011, 0, 0, 2);
    tag = "R4"; drive(4'b0011, 0, 0, 2);
    // R6 elevation in fixed mode
    tag = "R6"; drive(4'b1111, 0, 4'b0001, 2);
    tag = "R6"; drive(4'b1111, 0, 4'b1001, 2);
    // R7 write during busy must not move grant
    tag = "R7"; req = 4'b1111; busy = 4'b1111; elev = 0;
    cfg(1, 8'h00);
    tag = "R3"; drive(4'b1111, 4'b1111, 0, 2);
    // R5 round robin rotation
    tag = "R5"; drive(4'b1111, 0, 0, 6);
    tag = "R5"; drive(4'b0101, 0, 0, 4);
    // R6 elevation in round robin
    tag = "R6"; drive(4'b1111, 0, 4'b1010, 4);
    // R8 park with no request, then resume rotation
    tag = "R8"; drive(4'b0000, 0, 0, 3);
    tag = "R8"; drive(4'b1111, 0, 0, 2);
    // R2 random traffic against the model
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      if (n % 400 == 0) begin
        cfg_we = 1; cfg_mode = 1'($urandom); cfg_prio = 8'($urandom);
      end else cfg_we = 0;
      req  = 4'($urandom);
      busy = 4'($urandom) | 4'($urandom);
      elev = 4'($urandom) & 4'($urandom) & 4'($urandom);
      step();
    end
    cfg_we = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule